// File: doc/BRIEF.md
# Microcode Sequencer with Full-Stall Control

This block is the control core of a microcoded geometry engine. It holds a 15-bit program counter that fetches one 32-bit control word per cycle from an internal code store, a 14-bit data pointer into a 32-bit data store, and a separate pointer that names registers in a downstream raster unit. Each control word carries an opcode in its top three bits; the sequencer executes sequential steps, unconditional branches, conditional jumps on one of four external condition flags, pointer loads, a transfer of one data word to the raster unit, and a halt. Arithmetic, floating-point work and any further instruction fields belong to other blocks. This block only drives a clock enable for the floating-point unit.

A single full-stall input freezes the whole engine. While it is high the program counter, the data pointer and the raster pointer hold, the floating-point clock enable is low, and no raster transfer is offered. The host reaches the code store, the data store, the program counter and a run/halt control through a single-word write path. The memory and counter targets are accepted only while the engine is halted or stalled. The raster pointer has no host path at all: raster registers are reached only by microcode.

The raster output is a valid/ready stream. A transfer is offered while the engine runs unstalled on a transfer word, and completes on a cycle with both valid and ready high. While ready is low the sequencer waits with address and data held, and the floating-point enable stays low. A stall or a host halt withdraws the offer, because a stall freezes everything. The host path is also valid/ready. A write completes on a cycle with valid and ready high, and a write presented while ready is low has no effect.

Top module: `useq_core`

## Requirements
- R1: After reset the engine is halted, the program counter is 0, the data and raster pointers are 0, and rs_valid_o and fpu_ce_o are low.
- R2: A running, unstalled engine moves the program counter to PC+1, modulo 2^15, after opcode 0 (step), 3, 4, 6, 7 and an accepted opcode 5. PC 0x7FFF steps to 0. Code is fetched at the low CODE_AW bits of the PC.
- R3: Opcode 1 (branch) loads the PC from word bits [14:0].
- R4: Opcode 2 (conditional jump) tests cond_i at the index given by word bits [28:27]. If that flag is 1 the PC is loaded from bits [14:0]; otherwise it becomes PC+1.
- R5: Opcode 3 loads the data pointer from word bits [13:0]. The data store is addressed by the low DMEM_AW bits of the pointer, so higher addresses wrap into the populated range.
- R6: Opcode 4 loads the raster pointer from word bits [RP_W-1:0]. No host write changes the raster pointer.
- R7: Opcode 5 offers rs_valid_o with rs_addr_o equal to the raster pointer and rs_data_o equal to the data word at the data pointer. On acceptance both pointers increment by one and the PC steps. While rs_ready_i is low, the PC, address and data hold and fpu_ce_o is low.
- R8: While stall_i is high, the PC and both pointers hold (except for an accepted host PC write), and fpu_ce_o and rs_valid_o are low.
- R9: fpu_ce_o is high exactly in the cycles in which the engine advances, and it is never high while the engine is halted.
- R10: host_ready_o is always high for host_sel_i = 3 (control). For 0 (code), 1 (data) and 2 (PC) it is high only while the engine is halted or stall_i is high.
- R11: An accepted host write with host_sel_i = 2 sets the PC to host_addr_i. Writes with 0 or 1 store host_wdata_i in the code or data store at the low CODE_AW or DMEM_AW bits of host_addr_i.
- R12: Opcode 6 halts the engine and steps the PC. An accepted control write with host_wdata_i[0] = 1 starts the engine, and one with host_wdata_i[0] = 0 halts it. A control write wins over opcode 6 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Full-stall request: freezes the engine |
| cond_i | input | 4 | Condition flags tested by conditional jumps |
| host_valid_i | input | 1 | Host write request |
| host_ready_o | output | 1 | Host write accepted this cycle when valid |
| host_sel_i | input | 2 | Host target: 0 code, 1 data, 2 PC, 3 run/halt control |
| host_addr_i | input | 15 | Host address, or new PC value |
| host_wdata_i | input | 32 | Host write data; bit 0 is the run flag for control |
| rs_valid_o | output | 1 | Raster transfer offered |
| rs_ready_i | input | 1 | Raster unit accepts the transfer |
| rs_addr_o | output | RP_W | Raster register index |
| rs_data_o | output | 32 | Raster register value |
| fpu_ce_o | output | 1 | Clock enable for the floating-point unit |
| pc_o | output | 15 | Current program counter |
| halted_o | output | 1 | Engine halted |

## Verification
The hardest state to reach from the ports is a raster transfer that is held back by the raster unit and then frozen by a stall. In that state back-pressure and stall overlap on the same control word, and a rejected host PC write is presented at the same time. The directed part of the stimulus loads a program that sets both pointers to wrapping values, parks on a transfer with ready low, raises the stall, offers host writes, and then releases everything in turn. A random loop then drives conditional jumps with random selectors, flag patterns and targets.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int PC_W   = 15;
  localparam int MP_W   = 14;
  localparam int WORD_W = 32;
  localparam int NCOND  = 4;

  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_BR   = 3'd1,
    OP_JC   = 3'd2,
    OP_LDMP = 3'd3,
    OP_LDRP = 3'd4,
    OP_XFER = 3'd5,
    OP_HALT = 3'd6,
    OP_SPR  = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    HS_CODE = 2'd0,
    HS_DATA = 2'd1,
    HS_PC   = 2'd2,
    HS_CTRL = 2'd3
  } hsel_e;

  typedef struct packed {
    op_e         op;
    logic [1:0]  csel;
    logic [26:0] imm;
  } uword_t;
endpackage

// File: rtl/useq_store.sv
module useq_store #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/useq_pc_unit.sv
module useq_pc_unit
  import useq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  op_e              op_i,
  input  logic [1:0]       csel_i,
  input  logic [NCOND-1:0] cond_i,
  input  logic [PC_W-1:0]  target_i,
  input  logic             host_we_i,
  input  logic [PC_W-1:0]  host_pc_i,
  output logic [PC_W-1:0]  pc_o
);
  logic [PC_W-1:0] pc_q, pc_inc, pc_nxt;

  assign pc_inc = pc_q + PC_W'(1);

  always_comb begin
    unique case (op_i)
      OP_BR:   pc_nxt = target_i;
      OP_JC:   pc_nxt = cond_i[csel_i] ? target_i : pc_inc;
      default: pc_nxt = pc_inc;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pc_q <= '0;
    else if (host_we_i) pc_q <= host_pc_i;
    else if (adv_i)     pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/useq_ptr_unit.sv
module useq_ptr_unit
  import useq_pkg::*;
#(
  parameter int RP_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  op_e             op_i,
  input  logic [MP_W-1:0] mp_imm_i,
  input  logic [RP_W-1:0] rp_imm_i,
  output logic [MP_W-1:0] mp_o,
  output logic [RP_W-1:0] rp_o
);
  logic [MP_W-1:0] mp_q;
  logic [RP_W-1:0] rp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mp_q <= '0;
      rp_q <= '0;
    end else if (adv_i) begin
      unique case (op_i)
        OP_LDMP: mp_q <= mp_imm_i;
        OP_LDRP: rp_q <= rp_imm_i;
        OP_XFER: begin
          mp_q <= mp_q + MP_W'(1);
          rp_q <= rp_q + RP_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign mp_o = mp_q;
  assign rp_o = rp_q;
endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int CODE_AW = 10,
  parameter int DMEM_AW = 10,
  parameter int RP_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [NCOND-1:0]  cond_i,
  input  logic              host_valid_i,
  output logic              host_ready_o,
  input  logic [1:0]        host_sel_i,
  input  logic [PC_W-1:0]   host_addr_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  output logic              rs_valid_o,
  input  logic              rs_ready_i,
  output logic [RP_W-1:0]   rs_addr_o,
  output logic [WORD_W-1:0] rs_data_o,
  output logic              fpu_ce_o,
  output logic [PC_W-1:0]   pc_o,
  output logic              halted_o
);
  logic              halted_q;
  logic [PC_W-1:0]   pc;
  logic [MP_W-1:0]   mp;
  logic [RP_W-1:0]   rp;
  logic [WORD_W-1:0] code_rd, data_rd;
  uword_t            uw;
  logic              is_xfer, adv, hs_fire;
  logic              hw_code, hw_data, hw_pc, hw_ctrl;

  assign host_ready_o = (hsel_e'(host_sel_i) == HS_CTRL) || halted_q || stall_i;
  assign hs_fire      = host_valid_i && host_ready_o;
  assign hw_code      = hs_fire && (hsel_e'(host_sel_i) == HS_CODE);
  assign hw_data      = hs_fire && (hsel_e'(host_sel_i) == HS_DATA);
  assign hw_pc        = hs_fire && (hsel_e'(host_sel_i) == HS_PC);
  assign hw_ctrl      = hs_fire && (hsel_e'(host_sel_i) == HS_CTRL);

  useq_store #(.AW(CODE_AW), .DW(WORD_W)) u_code (
    .clk_i   (clk_i),
    .we_i    (hw_code),
    .waddr_i (host_addr_i[CODE_AW-1:0]),
    .wdata_i (host_wdata_i),
    .raddr_i (pc[CODE_AW-1:0]),
    .rdata_o (code_rd)
  );

  useq_store #(.AW(DMEM_AW), .DW(WORD_W)) u_data (
    .clk_i   (clk_i),
    .we_i    (hw_data),
    .waddr_i (host_addr_i[DMEM_AW-1:0]),
    .wdata_i (host_wdata_i),
    .raddr_i (mp[DMEM_AW-1:0]),
    .rdata_o (data_rd)
  );

  assign uw      = uword_t'(code_rd);
  assign is_xfer = !halted_q && (uw.op == OP_XFER);
  assign adv     = !halted_q && !stall_i && (!is_xfer || rs_ready_i);

  useq_pc_unit u_pc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .adv_i     (adv),
    .op_i      (uw.op),
    .csel_i    (uw.csel),
    .cond_i    (cond_i),
    .target_i  (uw.imm[PC_W-1:0]),
    .host_we_i (hw_pc),
    .host_pc_i (host_addr_i),
    .pc_o      (pc)
  );

  useq_ptr_unit #(.RP_W(RP_W)) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (adv),
    .op_i     (uw.op),
    .mp_imm_i (uw.imm[MP_W-1:0]),
    .rp_imm_i (uw.imm[RP_W-1:0]),
    .mp_o     (mp),
    .rp_o     (rp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      halted_q <= 1'b1;
    else if (hw_ctrl)                 halted_q <= ~host_wdata_i[0];
    else if (adv && uw.op == OP_HALT) halted_q <= 1'b1;
  end

  assign rs_valid_o = is_xfer && !stall_i;
  assign rs_addr_o  = rp;
  assign rs_data_o  = data_rd;
  assign fpu_ce_o   = adv;
  assign pc_o       = pc;
  assign halted_o   = halted_q;
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int RP_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            stall_i,
  input logic            host_valid_i,
  input logic            host_ready_o,
  input logic [1:0]      host_sel_i,
  input logic [14:0]     host_addr_i,
  input logic            rs_valid_o,
  input logic            rs_ready_i,
  input logic [RP_W-1:0] rs_addr_o,
  input logic [31:0]     rs_data_o,
  input logic            fpu_ce_o,
  input logic [14:0]     pc_o,
  input logic            halted_o
);
  logic ctrl_wr, pc_wr;
  assign ctrl_wr = host_valid_i && host_sel_i == 2'd3;
  assign pc_wr   = host_valid_i && host_ready_o && host_sel_i == 2'd2;

  // R8: the stall freezes the PC
  a_r8_pc_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i && !pc_wr |=> $stable(pc_o));

  // R8: a stall drops the clock enable and the raster offer
  a_r8_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !fpu_ce_o && !rs_valid_o);

  // R7: a held-back transfer keeps its address and data
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o && !rs_ready_i && !ctrl_wr |=>
      stall_i || (rs_valid_o && $stable(rs_addr_o) && $stable(rs_data_o)));

  // R7: back-pressure keeps the floating-point unit idle
  a_r7_bp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rs_valid_o && !rs_ready_i |-> !fpu_ce_o);

  // R9: no clock enable while halted
  a_r9_halt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !fpu_ce_o);

  // R11: an accepted PC write lands
  a_r11_pc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr |=> pc_o == $past(host_addr_i));

  // R12: only a control write leaves the halted state
  a_r12_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !ctrl_wr |=> halted_o);
endmodule

bind useq_core useq_checker #(.RP_W(RP_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .host_valid_i (host_valid_i),
  .host_ready_o (host_ready_o),
  .host_sel_i   (host_sel_i),
  .host_addr_i  (host_addr_i),
  .rs_valid_o   (rs_valid_o),
  .rs_ready_i   (rs_ready_i),
  .rs_addr_o    (rs_addr_o),
  .rs_data_o    (rs_data_o),
  .fpu_ce_o     (fpu_ce_o),
  .pc_o         (pc_o),
  .halted_o     (halted_o)
);

// File: tb/tb_useq_core.sv
`timescale 1ns/1ps
module tb_useq_core;
  localparam int CODE_AW = 10;
  localparam int DMEM_AW = 10;
  localparam int RP_W    = 8;

  logic        clk_i = 0, rst_ni = 0, stall_i = 0;
  logic [3:0]  cond_i = 0;
  logic        host_valid_i = 0, host_ready_o;
  logic [1:0]  host_sel_i = 0;
  logic [14:0] host_addr_i = 0;
  logic [31:0] host_wdata_i = 0;
  logic        rs_valid_o, rs_ready_i = 0;
  logic [RP_W-1:0] rs_addr_o;
  logic [31:0] rs_data_o;
  logic        fpu_ce_o, halted_o;
  logic [14:0] pc_o;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  useq_core #(.CODE_AW(CODE_AW), .DMEM_AW(DMEM_AW), .RP_W(RP_W)) dut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk(logic [2:0] op, logic [1:0] cs, logic [26:0] imm);
    return {op, cs, imm};
  endfunction

  function automatic logic [14:0] exp_jc(logic [3:0] c, logic [1:0] cs, logic [14:0] tgt, logic [14:0] pc);
    return c[cs] ? tgt : pc + 15'd1;
  endfunction

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(logic [1:0] sel, logic [14:0] a, logic [31:0] d);
    host_valid_i = 1; host_sel_i = sel; host_addr_i = a; host_wdata_i = d;
    tick();
    host_valid_i = 0;
  endtask

  initial begin
    void'($urandom(32'h1B2C3D4E));
    repeat (3) tick();
    rst_ni = 1;
    tick();
    // R1 reset state
    chk("R1 halted", halted_o, 1);
    chk("R1 pc", pc_o, 0);
    chk("R1 ce", fpu_ce_o, 0);
    chk("R1 valid", rs_valid_o, 0);

    for (int i = 0; i < (1 << CODE_AW); i++) hwr(2'd0, 15'(i), mk(3'd6, 0, 0));

    // R2 PC wrap at 0x7FFF, fetch at low code bits
    hwr(2'd0, 15'h7FFF, mk(3'd0, 0, 0));
    hwr(2'd2, 15'h7FFF, 0);
    chk("R11 pc write", pc_o, 15'h7FFF);
    hwr(2'd3, 0, 1);
    chk("R9 ce running", fpu_ce_o, 1);
    tick();
    chk("R2 pc wrap", pc_o, 0);
    tick();
    chk("R12 halt op halts", halted_o, 1);
    chk("R12 halt op steps", pc_o, 1);

    // directed program
    hwr(2'd0, 0, mk(3'd3, 0, 27'h2005));
    hwr(2'd0, 1, mk(3'd4, 0, 27'h33));
    hwr(2'd0, 2, mk(3'd5, 0, 0));
    hwr(2'd0, 3, mk(3'd5, 0, 0));
    hwr(2'd0, 4, mk(3'd1, 0, 27'd8));
    hwr(2'd0, 8, mk(3'd2, 2'd2, 27'd20));
    hwr(2'd1, 15'h0405, 32'hA5A5_0005);
    hwr(2'd1, 15'h0006, 32'h5A5A_0006);
    hwr(2'd2, 0, 0);
    rs_ready_i = 0;
    hwr(2'd3, 0, 1);
    chk("R5 ldmp ce", fpu_ce_o, 1);
    tick();
    chk("R2 step", pc_o, 1);
    tick();
    chk("R7 valid", rs_valid_o, 1);
    chk("R6 rs addr", rs_addr_o, 8'h33);
    chk("R5 wrapped data", rs_data_o, 32'hA5A5_0005);
    chk("R7 ce low bp", fpu_ce_o, 0);
    // R10 host PC write refused while running
    host_valid_i = 1; host_sel_i = 2'd2; host_addr_i = 15'h1234; #0.5;
    chk("R10 ready low", host_ready_o, 0);
    tick();
    host_valid_i = 0;
    chk("R10 pc unchanged", pc_o, 2);
    tick(); tick();
    chk("R7 pc held", pc_o, 2);
    chk("R7 addr held", rs_addr_o, 8'h33);
    stall_i = 1; #0.5;
    chk("R8 valid low", rs_valid_o, 0);
    chk("R8 ce low", fpu_ce_o, 0);
    host_sel_i = 2'd0; #0.5;
    chk("R10 ready in stall", host_ready_o, 1);
    rs_ready_i = 1;
    tick(); tick();
    chk("R8 pc frozen", pc_o, 2);
    chk("R8 rp frozen", rs_addr_o, 8'h33);
    stall_i = 0; #0.5;
    chk("R9 ce on accept", fpu_ce_o, 1);
    tick();
    chk("R7 pc step", pc_o, 3);
    chk("R7 rp inc", rs_addr_o, 8'h34);
    chk("R7 mp inc", rs_data_o, 32'h5A5A_0006);
    tick();
    chk("R2 after xfer", pc_o, 4);
    tick();
    chk("R3 branch", pc_o, 8);
    cond_i = 4'b0100;
    tick();
    chk("R4 jump taken", pc_o, 20);
    rs_ready_i = 0;
    tick();
    chk("R12 halted", halted_o, 1);
    chk("R9 ce halted", fpu_ce_o, 0);

    // R4 random conditional jumps
    for (int k = 0; k < 60; k++) begin
      logic [1:0] cs;
      logic [3:0] cv;
      logic [14:0] tg;
      cs = 2'($urandom); cv = 4'($urandom); tg = 15'($urandom);
      hwr(2'd0, 0, mk(3'd2, cs, 27'(tg)));
      cond_i = cv;
      hwr(2'd2, 0, 0);
      hwr(2'd3, 0, 1);
      tick();
      chk("R4 random jump", pc_o, exp_jc(cv, cs, tg, 15'd0));
      hwr(2'd3, 0, 0);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule